// File: doc/BRIEF.md
# Dual-Edge Strobed Write Capture with Byte Masking

This block is the write data path on the memory side of a double-data-rate interface. After a write command it waits out a fixed write latency. It then takes one data beat from the narrow data bus at every level change of the incoming data strobe, both rising and falling. Each pair of beats becomes one internal word of twice the bus width. That word goes into a behavioural storage array. Each byte lane of a beat can be blocked by its own mask bit, and a blocked lane keeps its old contents.

The strobe is not used as a clock. A fast sampling clock `clk` (twice the command clock) samples it, and a beat is any sample whose strobe level differs from the previous sample. A burst carries 2, 4 or 8 beats, which is 1, 2 or 4 internal words. The words go to consecutive column addresses that wrap inside the block of word addresses aligned to the burst size. A combinational read port exposes the array for the surrounding logic.

The controller has three states. `S_IDLE` waits for a command and ignores strobe activity. `S_ALIGN` counts the write latency. `S_BURST` accepts beats. The transitions are:
- `IDLE->ALIGN` on `wr_cmd`.
- `ALIGN->BURST` when the latency count expires.
- `BURST->IDLE` when the last word of the burst is written.

Top module: `wcap_top`

## Requirements
- R1: After reset every array word reads as zero, and strobe activity before any command writes nothing.
- R2: A command sampled at a `clk` edge opens the beat window at the second following `clk` edge, which is one command-clock cycle later. Strobe level changes sampled before that edge are ignored.
- R3: Inside the beat window, every `clk` edge at which `dqs` differs from its level at the previous edge captures exactly one beat from `dq` and `dm`. Both rising and falling strobe changes count.
- R4: Within each internal word, the even beat of a pair fills bits [DQ_W-1:0] and the odd beat fills bits [2*DQ_W-1:DQ_W]. The word is written at the edge that captures the odd beat.
- R5: `wr_bl` selects the burst length: 2'b00 is 2 beats, 2'b01 is 4 beats, and 2'b10 or 2'b11 is 8 beats. The block returns to idle at the edge that writes the last word.
- R6: Internal word k of a burst (k from 0) goes to address `(col & ~(N-1)) | ((col + k) & (N-1))`, where N is the number of words in the burst.
- R7: `dm[i]` high during a beat discards byte lane i (bits 8i+7:8i) of that beat, and the array keeps that lane's previous value.
- R8: `wr_cmd` asserted while a burst is aligning or in progress has no effect.
- R9: Strobe level changes sampled in the idle state write nothing.
- R10: `rd_data` always shows the array word at `rd_col` without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock, twice the command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_cmd | input | 1 | Write command strobe, one cycle |
| wr_col | input | COL_W | Starting word column of the burst |
| wr_bl | input | 2 | Burst length code |
| dqs | input | 1 | Data strobe level as sampled |
| dq | input | DQ_W | Write data beat |
| dm | input | DQ_W/8 | Per-lane discard mask of the beat |
| rd_col | input | COL_W | Read column |
| rd_data | output | 2*DQ_W | Array word at rd_col |

## Verification
The hardest situation to reach is strobe activity that arrives too early. This means a level change in the single aligning cycle between the command and the beat window, or a new command issued in the middle of a burst that would otherwise restart the address sequence. Directed sequences place a junk beat exactly in the aligning cycle and raise `wr_cmd` during a data beat. The full array is then compared against a bench model. Random bursts with random columns, lengths and masks cover the wrap patterns and the mask mixtures in between.

// File: rtl/wcap_pkg.sv
package wcap_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ALIGN = 2'd1,
        S_BURST = 2'd2
    } wcap_state_e;

    // words per burst minus one, from the burst length code
    function automatic logic [2:0] words_mask(input logic [1:0] bl);
        case (bl)
            2'b00:   return 3'd0;
            2'b01:   return 3'd1;
            default: return 3'd3;
        endcase
    endfunction
endpackage

// File: rtl/wcap_edge.sv
module wcap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic dqs,
    output logic edge_o
);
    logic dqs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) dqs_q <= 1'b0;
        else        dqs_q <= dqs;
    end

    assign edge_o = dqs ^ dqs_q;
endmodule

// File: rtl/wcap_pair.sv
module wcap_pair #(
    parameter int DQ_W = 16,
    localparam int DM_W = DQ_W / 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                beat,
    input  logic [DQ_W-1:0]     dq,
    input  logic [DM_W-1:0]     dm,
    output logic                half,
    output logic                commit,
    output logic [2*DQ_W-1:0]   word,
    output logic [2*DM_W-1:0]   wmask
);
    logic [DQ_W-1:0] low_q;
    logic [DM_W-1:0] lowm_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            half   <= 1'b0;
            low_q  <= '0;
            lowm_q <= '0;
        end else if (beat) begin
            half <= ~half;
            if (!half) begin
                low_q  <= dq;
                lowm_q <= dm;
            end
        end
    end

    assign commit = beat & half;
    assign word   = {dq, low_q};
    assign wmask  = {dm, lowm_q};
endmodule

// File: rtl/wcap_addr.sv
module wcap_addr #(
    parameter int COL_W = 4
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  logic [COL_W-1:0] nmask,
    output logic [COL_W-1:0] addr
);
    logic [COL_W-1:0] sum;
    assign sum  = base + idx;
    assign addr = (base & ~nmask) | (sum & nmask);
endmodule

// File: rtl/wcap_top.sv
module wcap_top #(
    parameter int DQ_W    = 16,
    parameter int COL_W   = 4,
    parameter int LAT_CYC = 2,
    localparam int DM_W   = DQ_W / 8,
    localparam int WORD_W = 2 * DQ_W,
    localparam int LANES  = 2 * DM_W,
    localparam int DEPTH  = 1 << COL_W,
    localparam int CNT_W  = $clog2(LAT_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [1:0]        wr_bl,
    input  logic              dqs,
    input  logic [DQ_W-1:0]   dq,
    input  logic [DM_W-1:0]   dm,
    input  logic [COL_W-1:0]  rd_col,
    output logic [WORD_W-1:0] rd_data
);
    import wcap_pkg::*;

    wcap_state_e      st, st_nx;
    logic [CNT_W-1:0] cnt;
    logic [COL_W-1:0] base_q, nmask_q, widx, waddr;
    logic             sedge, beat, half, commit, last, start;
    logic [WORD_W-1:0] word;
    logic [LANES-1:0]  wmask;
    logic [WORD_W-1:0] mem [DEPTH];

    wcap_edge u_edge (.clk(clk), .rst_n(rst_n), .dqs(dqs), .edge_o(sedge));

    wcap_pair #(.DQ_W(DQ_W)) u_pair (
        .clk(clk), .rst_n(rst_n), .clr(start), .beat(beat), .dq(dq), .dm(dm),
        .half(half), .commit(commit), .word(word), .wmask(wmask)
    );

    wcap_addr #(.COL_W(COL_W)) u_addr (
        .base(base_q), .idx(widx), .nmask(nmask_q), .addr(waddr)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // next state and control outputs
    always_comb begin
        st_nx = st;
        start = 1'b0;
        beat  = 1'b0;
        last  = (widx == nmask_q);
        unique case (st)
            S_IDLE: begin
                start = wr_cmd;
                if (wr_cmd) st_nx = (LAT_CYC <= 1) ? S_BURST : S_ALIGN;
            end
            S_ALIGN: begin
                if (cnt == CNT_W'(LAT_CYC - 2)) st_nx = S_BURST;
            end
            S_BURST: begin
                beat = sedge;
                if (commit && last) st_nx = S_IDLE;
            end
            default: st_nx = S_IDLE;
        endcase
    end

    // burst bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            base_q  <= '0;
            nmask_q <= '0;
            widx    <= '0;
        end else if (start) begin
            cnt     <= '0;
            base_q  <= wr_col;
            nmask_q <= COL_W'(words_mask(wr_bl));
            widx    <= '0;
        end else begin
            if (st == S_ALIGN) cnt <= cnt + 1'b1;
            if (commit)        widx <= widx + 1'b1;
        end
    end

    // storage array with per-lane write enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
        end else if (commit) begin
            for (int l = 0; l < LANES; l++)
                if (!wmask[l]) mem[waddr][l*8 +: 8] <= word[l*8 +: 8];
        end
    end

    assign rd_data = mem[rd_col];
endmodule

// File: rtl/wcap_chk.sv
module wcap_chk #(
    parameter int COL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_cmd,
    input logic [1:0]       st,
    input logic             beat,
    input logic             half,
    input logic             commit,
    input logic             last,
    input logic [COL_W-1:0] waddr,
    input logic [COL_W-1:0] base_q,
    input logic [COL_W-1:0] nmask_q
);
    AST_CMD_TO_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'd0 && wr_cmd) |=> (st != 2'd0)) else $error("cmd"); // R2
    AST_NO_COMMIT_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (st == 2'd2)) else $error("commit"); // R9
    AST_ADDR_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (((waddr ^ base_q) & ~nmask_q) == '0)) else $error("addr"); // R6
    AST_BURST_END: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && last) |=> (st == 2'd0)) else $error("end"); // R5
    AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !half) |=> half) else $error("pair"); // R4
    AST_BUSY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'd2 && wr_cmd && !commit) |=> (st == 2'd2)) else $error("busy"); // R8
endmodule

bind wcap_top wcap_chk #(.COL_W(COL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .st(st), .beat(beat),
    .half(half), .commit(commit), .last(last), .waddr(waddr),
    .base_q(base_q), .nmask_q(nmask_q)
);

// File: tb/tb_wcap_top.sv
module tb_wcap_top;
    localparam int DQ_W = 16, COL_W = 4, DM_W = 2, DEPTH = 16, WW = 32;

    logic clk = 0, rst_n = 0, wr_cmd = 0, dqs = 0;
    logic [COL_W-1:0] wr_col = 0, rd_col = 0;
    logic [1:0] wr_bl = 0;
    logic [DQ_W-1:0] dq = 0;
    logic [DM_W-1:0] dm = 0;
    logic [WW-1:0] rd_data;
    logic [WW-1:0] model [DEPTH];
    int checks = 0, errors = 0;
    bit done = 0;

    wcap_top #(.DQ_W(DQ_W), .COL_W(COL_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wr_col(wr_col), .wr_bl(wr_bl),
        .dqs(dqs), .dq(dq), .dm(dm), .rd_col(rd_col), .rd_data(rd_data));

    always #10 clk = ~clk;

    function automatic int nwords(input logic [1:0] bl);
        return (bl == 2'b00) ? 1 : (bl == 2'b01) ? 2 : 4;
    endfunction

    function automatic logic [COL_W-1:0] ref_addr(input logic [COL_W-1:0] c, input int k, input int n);
        logic [COL_W-1:0] m;
        m = COL_W'(n - 1);
        return (c & ~m) | (COL_W'(c + COL_W'(k)) & m);
    endfunction

    task automatic check(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            rd_col = COL_W'(a);
            #1 check(req, rd_data, model[a]);
        end
    endtask

    // one burst; junk: a strobe change in the aligning cycle; busy: cmd raised mid-burst
    task automatic burst(input logic [COL_W-1:0] c, input logic [1:0] bl, input bit junk,
                         input bit busy, input bit fullmask);
        int n, nb;
        logic [DQ_W-1:0] d;
        logic [DM_W-1:0] m;
        logic [COL_W-1:0] a;
        n = nwords(bl);
        nb = 2 * n;
        @(negedge clk);
        wr_cmd = 1; wr_col = c; wr_bl = bl;
        @(negedge clk);
        wr_cmd = 0; wr_col = ~c;
        if (junk) begin dqs = ~dqs; dq = 16'hDEAD; dm = 0; end
        for (int b = 0; b < nb; b++) begin
            @(negedge clk);
            d = DQ_W'($urandom);
            m = fullmask ? 2'b11 : DM_W'($urandom);
            dqs = ~dqs; dq = d; dm = m;
            wr_cmd = (busy && b == 1);
            a = ref_addr(c, b / 2, n);
            for (int l = 0; l < DM_W; l++)
                if (!m[l]) model[a][(b % 2) * DQ_W + l * 8 +: 8] = d[l * 8 +: 8];
        end
        @(negedge clk);
        wr_cmd = 0;
    endtask

    initial begin
        void'($urandom(32'h5eed));
        for (int a = 0; a < DEPTH; a++) model[a] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        sweep("R1 reset");
        // R9 / R1: strobe activity while idle
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            dqs = ~dqs; dq = DQ_W'($urandom); dm = 0;
        end
        sweep("R9 idle edges");
        // R6 wrap: start at 3 with 8 beats -> 3,0,1,2; R4 pairing, R3 both edges
        burst(4'd3, 2'b10, 0, 0, 0);
        sweep("R6 wrap R3 R4");
        // R2 early edge in aligning cycle
        burst(4'd9, 2'b01, 1, 0, 0);
        sweep("R2 early edge");
        // R8 command while busy
        burst(4'd14, 2'b11, 0, 1, 0);
        sweep("R8 busy cmd");
        // R7 fully masked burst
        burst(4'd5, 2'b00, 0, 0, 1);
        sweep("R7 full mask");
        // random bursts R5 R7 R10
        for (int i = 0; i < 40; i++) begin
            burst(COL_W'($urandom), 2'($urandom), 0, 0, 0);
            repeat ($urandom % 3) @(negedge clk);
        end
        sweep("R5 R7 R10 random");
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule